// File: doc/BRIEF.md
# Protection and Soft-Start Sequencer

This block decides when the deflection power stages of a monitor may run. Three fault sources force it into a safe state: a low-supply flag, an X-ray over-threshold flag that has to persist before it trips, and an external force-off request. In the safe state the horizontal drive, the power (B+) drive and the vertical outputs are disabled, a continuous blank is requested, and the phase and frequency loops are held off.

Leaving the safe state is a soft start. An internal counter stands in for the charging ramp capacitor. The horizontal drive pulse width grows with the ramp until it reaches its final value. The power drive and vertical outputs come back at a middle ramp level. At the top level the blank is released and the loops are enabled. After a supply fault every step also waits for its own supply-threshold flag. After a force-off the ramp alone decides. The X-ray trip is latched until the supply goes away. A force-off freezes the ramp instead of discharging it.

Top module: `defl_protect_seq`

## Requirements
- R1: While `rst` is high, and on the first edge after it, the outputs are as follows: `hdrv_en`, `pdrv_en`, `vout_en` and `loops_en` are 0, `blank_req` is 1 and `hdrv_width` is 0.
- R2: An X-ray trip latches at the clock edge on which `xray_over` has been high for `XRAY_CNT` consecutive edges. A shorter burst has no effect. The latch stays set until an edge with `supply_low` high.
- R3: Protection is the OR of `supply_low`, `force_off` and the X-ray latch. At the edge where it is seen, every enable drops to 0, `blank_req` goes to 1 and `hdrv_width` goes to 0.
- R4: The ramp is cleared to 0 on an edge with `supply_low` high or with the latch set. During `force_off` alone it keeps its value.
- R5: Outside protection the ramp rises by 1 per clock, up to `RAMP_RUN`. In supply-gated mode it rises only while `sup_hdrv_ok` is 1.
- R6: Outputs are registered from the ramp value held before the edge. Outside protection, `hdrv_en` is 1 when the mode's horizontal supply condition holds, and `hdrv_width` is then min(ramp, `RAMP_DUTY`). Otherwise both are 0.
- R7: `pdrv_en` and `vout_en` are 1 only outside protection, with ramp ≥ `RAMP_OUT`, and (in supply-gated mode) `sup_out_ok` high.
- R8: `loops_en` is 1 and `blank_req` is 0 only outside protection, with ramp ≥ `RAMP_RUN`, and (in supply-gated mode) `sup_run_ok` high.
- R9: Reset or `supply_low` sets supply-gated mode. The edge on which `loops_en` turns on clears it. Outside that mode the three supply flags are ignored, so release from a force-off follows the ramp alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_low | input | 1 | Supply below its minimum, also counts as supply removal |
| sup_hdrv_ok | input | 1 | Supply above the horizontal drive threshold |
| sup_out_ok | input | 1 | Supply above the power/vertical output threshold |
| sup_run_ok | input | 1 | Supply above the final run threshold |
| xray_over | input | 1 | X-ray detector above its threshold |
| force_off | input | 1 | External force-off request |
| hdrv_en | output | 1 | Horizontal drive enable |
| pdrv_en | output | 1 | Power drive enable |
| vout_en | output | 1 | Vertical output enable |
| blank_req | output | 1 | Continuous blank request |
| loops_en | output | 1 | Phase and frequency loop enable |
| hdrv_width | output | RAMP_W | Horizontal drive pulse-width limit |

## Verification
The bench builds the block with `RAMP_W`=5, `RAMP_DUTY`=6, `RAMP_OUT`=10, `RAMP_RUN`=16 and `XRAY_CNT`=4. With these values a full soft start takes about twenty cycles, and the width cap, both middle thresholds and the saturated ramp can each be reached with short directed waits. The small trip count allows an X-ray burst one cycle short of a trip next to an exact trip. The bench also holds the supply flags low around a force-off, to show that the release then follows the ramp alone.

// File: rtl/dps_pkg.sv
package dps_pkg;

  // Registered enable set driven by the output stage.
  typedef struct packed {
    logic hdrv;
    logic pdrv;
    logic vout;
    logic blank;
    logic loops;
  } dps_en_t;

  localparam dps_en_t DPS_SAFE = '{hdrv: 1'b0, pdrv: 1'b0, vout: 1'b0, blank: 1'b1, loops: 1'b0};

endpackage

// File: rtl/dps_xray_trip.sv
module dps_xray_trip #(
  parameter int XRAY_CNT = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_low,
  input  logic xray_over,
  output logic tripped
);
  localparam int CW = $clog2(XRAY_CNT + 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || supply_low) begin
      run_cnt <= '0;
      tripped <= 1'b0;
    end else begin
      if (!xray_over)
        run_cnt <= '0;
      else if (run_cnt != CW'(XRAY_CNT))
        run_cnt <= run_cnt + 1'b1;
      if (xray_over && run_cnt == CW'(XRAY_CNT - 1))
        tripped <= 1'b1;
    end
  end

  // R2: once set, only supply removal clears the latch
  p_latch_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (tripped && !supply_low) |=> tripped);

  // R2: a trip is always preceded by the over-threshold input
  p_trip_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(tripped) |-> $past(xray_over));

endmodule

// File: rtl/dps_ramp.sv
module dps_ramp #(
  parameter int RAMP_W   = 8,
  parameter int RAMP_RUN = 224
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply_low,
  input  logic              tripped,
  input  logic              force_off,
  input  logic              charge_ok,
  output logic [RAMP_W-1:0] ramp
);
  localparam logic [RAMP_W-1:0] TOP = RAMP_W'(RAMP_RUN);

  logic discharge;
  assign discharge = supply_low || tripped;

  always_ff @(posedge clk) begin
    if (rst || discharge)
      ramp <= '0;
    else if (!force_off && charge_ok && ramp < TOP)
      ramp <= ramp + 1'b1;
  end

  // R4: supply or X-ray protection empties the ramp
  p_discharge_r4: assert property (@(posedge clk) disable iff (rst)
    discharge |=> (ramp == '0));

  // R4: force-off alone freezes the ramp
  p_force_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (force_off && !discharge) |=> $stable(ramp));

  // R5: the ramp never passes its final level
  p_ramp_cap_r5: assert property (@(posedge clk) disable iff (rst)
    ramp <= TOP);

endmodule

// File: rtl/dps_out_stage.sv
module dps_out_stage
  import dps_pkg::*;
#(
  parameter int RAMP_W    = 8,
  parameter int RAMP_DUTY = 96,
  parameter int RAMP_OUT  = 160,
  parameter int RAMP_RUN  = 224
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prot,
  input  logic              supply_low,
  input  logic              sup_hdrv_ok,
  input  logic              sup_out_ok,
  input  logic              sup_run_ok,
  input  logic [RAMP_W-1:0] ramp,
  output logic              gated,
  output dps_en_t           en,
  output logic [RAMP_W-1:0] width
);
  localparam logic [RAMP_W-1:0] DUTY = RAMP_W'(RAMP_DUTY);
  localparam logic [RAMP_W-1:0] LVL_OUT = RAMP_W'(RAMP_OUT);
  localparam logic [RAMP_W-1:0] LVL_RUN = RAMP_W'(RAMP_RUN);

  logic ok_h, ok_o, ok_r;
  logic h_nx, o_nx, r_nx;

  always_comb begin
    ok_h = !gated || sup_hdrv_ok;
    ok_o = !gated || sup_out_ok;
    ok_r = !gated || sup_run_ok;
    h_nx = !prot && ok_h;
    o_nx = !prot && ok_o && (ramp >= LVL_OUT);
    r_nx = !prot && ok_r && (ramp >= LVL_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= DPS_SAFE;
      width <= '0;
      gated <= 1'b1;
    end else begin
      en.hdrv  <= h_nx;
      en.pdrv  <= o_nx;
      en.vout  <= o_nx;
      en.loops <= r_nx;
      en.blank <= !r_nx;
      width    <= h_nx ? ((ramp > DUTY) ? DUTY : ramp) : '0;
      if (supply_low)
        gated <= 1'b1;
      else if (r_nx)
        gated <= 1'b0;
    end
  end

  // R3: any protection source drives the safe state on the next edge
  p_prot_safe_r3: assert property (@(posedge clk) disable iff (rst)
    prot |=> (!en.hdrv && !en.pdrv && !en.vout && en.blank && !en.loops && width == '0));

  // R6: the width limit never exceeds the final duty
  p_width_cap_r6: assert property (@(posedge clk) disable iff (rst)
    width <= DUTY);

  // R7: power and vertical outputs only at or above their ramp level
  p_out_level_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(en.pdrv) |-> ($past(ramp) >= LVL_OUT));

  // R8: loops run only with all drives on and blank released
  p_loops_order_r8: assert property (@(posedge clk) disable iff (rst)
    en.loops |-> (en.pdrv && en.vout && en.hdrv && !en.blank));

  // R9: supply removal always returns to supply-gated mode
  p_gate_set_r9: assert property (@(posedge clk) disable iff (rst)
    supply_low |=> gated);

endmodule

// File: rtl/defl_protect_seq.sv
module defl_protect_seq
  import dps_pkg::*;
#(
  parameter int RAMP_W    = 8,
  parameter int RAMP_DUTY = 96,
  parameter int RAMP_OUT  = 160,
  parameter int RAMP_RUN  = 224,
  parameter int XRAY_CNT  = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply_low,
  input  logic              sup_hdrv_ok,
  input  logic              sup_out_ok,
  input  logic              sup_run_ok,
  input  logic              xray_over,
  input  logic              force_off,
  output logic              hdrv_en,
  output logic              pdrv_en,
  output logic              vout_en,
  output logic              blank_req,
  output logic              loops_en,
  output logic [RAMP_W-1:0] hdrv_width
);
  if (!(RAMP_DUTY > 0 && RAMP_DUTY <= RAMP_OUT && RAMP_OUT < RAMP_RUN &&
        RAMP_RUN < (2 ** RAMP_W) && XRAY_CNT >= 1)) begin : g_bad_cfg
    $error("defl_protect_seq: ramp levels must rise strictly and fit RAMP_W");
  end

  logic              tripped;
  logic              prot;
  logic              gated;
  logic              charge_ok;
  logic [RAMP_W-1:0] ramp;
  dps_en_t           en;

  assign prot      = supply_low || force_off || tripped;
  assign charge_ok = !gated || sup_hdrv_ok;

  dps_xray_trip #(.XRAY_CNT(XRAY_CNT)) u_xray (
    .clk(clk), .rst(rst), .supply_low(supply_low),
    .xray_over(xray_over), .tripped(tripped)
  );

  dps_ramp #(.RAMP_W(RAMP_W), .RAMP_RUN(RAMP_RUN)) u_ramp (
    .clk(clk), .rst(rst), .supply_low(supply_low), .tripped(tripped),
    .force_off(force_off), .charge_ok(charge_ok), .ramp(ramp)
  );

  dps_out_stage #(
    .RAMP_W(RAMP_W), .RAMP_DUTY(RAMP_DUTY),
    .RAMP_OUT(RAMP_OUT), .RAMP_RUN(RAMP_RUN)
  ) u_out (
    .clk(clk), .rst(rst), .prot(prot), .supply_low(supply_low),
    .sup_hdrv_ok(sup_hdrv_ok), .sup_out_ok(sup_out_ok), .sup_run_ok(sup_run_ok),
    .ramp(ramp), .gated(gated), .en(en), .width(hdrv_width)
  );

  assign hdrv_en   = en.hdrv;
  assign pdrv_en   = en.pdrv;
  assign vout_en   = en.vout;
  assign blank_req = en.blank;
  assign loops_en  = en.loops;

  // R1: first edge after reset leaves the safe state in place
  p_reset_safe_r1: assert property (@(posedge clk)
    $fell(rst) |-> (!hdrv_en && !pdrv_en && !loops_en && blank_req));

endmodule

// File: tb/defl_protect_seq_bench.sv
module defl_protect_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst, supply_low, sup_hdrv_ok, sup_out_ok, sup_run_ok, xray_over, force_off;
  logic hdrv_en, pdrv_en, vout_en, blank_req, loops_en;
  logic [RW-1:0] hdrv_width;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  defl_protect_seq #(
    .RAMP_W(RW), .RAMP_DUTY(6), .RAMP_OUT(10), .RAMP_RUN(16), .XRAY_CNT(4)
  ) u_defl_protect_seq (
    .clk(clk), .rst(rst), .supply_low(supply_low), .sup_hdrv_ok(sup_hdrv_ok),
    .sup_out_ok(sup_out_ok), .sup_run_ok(sup_run_ok), .xray_over(xray_over),
    .force_off(force_off), .hdrv_en(hdrv_en), .pdrv_en(pdrv_en), .vout_en(vout_en),
    .blank_req(blank_req), .loops_en(loops_en), .hdrv_width(hdrv_width)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_safe(input string req);
    chk(req, "hdrv_en", hdrv_en, 0);
    chk(req, "pdrv_en", pdrv_en, 0);
    chk(req, "vout_en", vout_en, 0);
    chk(req, "blank_req", blank_req, 1);
    chk(req, "loops_en", loops_en, 0);
    chk(req, "hdrv_width", hdrv_width, 0);
  endtask

  task automatic t_reset;
    chk_safe("R1");
    rst = 1'b0;
    tick(1);
    chk_safe("R1");
  endtask

  task automatic t_supply_start;
    supply_low = 1'b0; sup_hdrv_ok = 1'b0; sup_out_ok = 1'b0; sup_run_ok = 1'b0;
    tick(8);
    chk("R5", "hdrv_en gated", hdrv_en, 0);
    chk("R5", "width gated", hdrv_width, 0);
    sup_hdrv_ok = 1'b1;
    tick(1);
    chk("R6", "hdrv_en on", hdrv_en, 1);
    chk("R5", "ramp held while gated", hdrv_width, 0);
    tick(2);
    chk("R6", "width grows", hdrv_width, 2);
    tick(5);
    chk("R6", "width capped", hdrv_width, 6);
    tick(12);
    chk("R7", "pdrv waits supply", pdrv_en, 0);
    chk("R7", "vout waits supply", vout_en, 0);
    chk("R8", "blank held", blank_req, 1);
    sup_out_ok = 1'b1;
    tick(1);
    chk("R7", "pdrv on", pdrv_en, 1);
    chk("R7", "vout on", vout_en, 1);
    chk("R8", "loops wait supply", loops_en, 0);
    sup_run_ok = 1'b1;
    tick(1);
    chk("R8", "loops on", loops_en, 1);
    chk("R8", "blank off", blank_req, 0);
  endtask

  task automatic t_force_run;
    force_off = 1'b1;
    tick(1);
    chk_safe("R3");
    sup_hdrv_ok = 1'b0; sup_out_ok = 1'b0; sup_run_ok = 1'b0;
    tick(5);
    force_off = 1'b0;
    tick(1);
    chk("R9", "loops after force release", loops_en, 1);
    chk("R9", "pdrv ignores supply flags", pdrv_en, 1);
    chk("R4", "ramp kept full", hdrv_width, 6);
    sup_hdrv_ok = 1'b1; sup_out_ok = 1'b1; sup_run_ok = 1'b1;
  endtask

  task automatic t_force_midramp;
    supply_low = 1'b1;
    tick(1);
    chk_safe("R3");
    supply_low = 1'b0;
    tick(5);
    chk("R6", "width after five", hdrv_width, 4);
    force_off = 1'b1;
    tick(10);
    chk("R3", "blank during force", blank_req, 1);
    chk("R3", "width during force", hdrv_width, 0);
    force_off = 1'b0;
    tick(1);
    chk("R4", "ramp held through force", hdrv_width, 5);
    chk("R7", "pdrv still below level", pdrv_en, 0);
    tick(15);
    chk("R8", "loops after resumed ramp", loops_en, 1);
  endtask

  task automatic t_xray;
    xray_over = 1'b1;
    tick(3);
    xray_over = 1'b0;
    tick(1);
    chk("R2", "short burst ignored", loops_en, 1);
    xray_over = 1'b1;
    tick(4);
    chk("R2", "outputs lag trip edge", loops_en, 1);
    xray_over = 1'b0;
    tick(1);
    chk_safe("R2");
    tick(20);
    chk("R2", "latch holds blank", blank_req, 1);
    chk("R2", "latch holds hdrv off", hdrv_en, 0);
    supply_low = 1'b1;
    tick(1);
    supply_low = 1'b0;
    tick(3);
    chk("R2", "latch cleared by supply", hdrv_en, 1);
    chk("R4", "ramp was discharged", hdrv_width, 2);
  endtask

  task automatic t_supply_drop;
    tick(20);
    chk("R8", "running again", loops_en, 1);
    supply_low = 1'b1;
    tick(1);
    chk_safe("R3");
    supply_low = 1'b0;
  endtask

  initial begin
    rst = 1'b1; supply_low = 1'b1; sup_hdrv_ok = 1'b0; sup_out_ok = 1'b0;
    sup_run_ok = 1'b0; xray_over = 1'b0; force_off = 1'b0;
    tick(3);
    t_reset();
    t_supply_start();
    t_force_run();
    t_force_midramp();
    t_xray();
    t_supply_drop();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule